// File: doc/BRIEF.md
# Bridge Forwarding Decoder

This block is the routing decision logic of a logical bridge between a primary (upstream) and a secondary (downstream) bus, of the kind used for a root port or a switch port. It keeps the bridge window registers: an I/O window, a memory window limited to the space below 4 GB, a prefetchable memory window that spans the full 64-bit space, and the three bus numbers (primary, secondary, subordinate). For every request it answers with one of three routes: send it down to the secondary side, send it up to the primary side, or leave it unclaimed.

Requests from the primary side are claimed by positive decode against the windows, or by bus-number range for configuration accesses. Requests from the secondary side travel the other way: memory traffic that misses both memory windows goes up, so that device DMA reaches system memory, while traffic that hits a window stays below the bridge. An optional subtractive mode lets the bridge take any primary I/O or memory request that no other agent on the bus claimed, one cycle after the request.

Every result appears on the output exactly two clock cycles after the request, in request order. The window and bus-number registers are loaded through a simple write strobe with a register select.

Top module: `p2p_fwd_decoder`

## Requirements
- R1: After reset no result is valid, every window is disabled, subtractive mode is off and all bus numbers are zero, so a primary I/O or memory request is left unclaimed.
- R2: A request accepted with req_valid_i high in cycle T gives exactly one result with fwd_valid_o high in cycle T+2; results keep request order. Route encoding: 0 none, 1 down, 2 up. Kind encoding: 0 I/O, 1 memory, 2 configuration. Side encoding: 0 primary, 1 secondary.
- R3: A primary I/O request goes down only when the I/O window is enabled and address bits [31:12] lie between the base and limit pages inclusive; any address with a nonzero bit above bit 31 misses the I/O window.
- R4: A primary memory request goes down when address bits [31:20] lie inclusively inside the enabled memory window and bits above 31 are zero; an address at or above 4 GB never hits this window.
- R5: A primary memory request also goes down when address bits [63:20] lie inclusively inside the enabled prefetchable window, at any 64-bit address.
- R6: A window is enabled only when its limit page is strictly greater than its base page; an equal or lower limit disables it, for both directions.
- R7: A secondary memory request that hits neither enabled memory window goes up.
- R8: A secondary memory request that hits either memory window is left unclaimed, and secondary I/O and configuration requests are left unclaimed.
- R9: With subtractive mode off, a primary I/O or memory request outside every window is left unclaimed.
- R10: A primary configuration request whose bus equals the secondary bus number goes down with fwd_type0_o high; fwd_type0_o is low for every other result.
- R11: A primary configuration request whose bus is above the secondary number and at most the subordinate number goes down with fwd_type0_o low; any other bus, and always the primary bus number, is left unclaimed.
- R12: With subtractive mode on, a primary I/O or memory request that misses its windows goes down if peer_claim_i is low in the cycle after the request and is left unclaimed if it is high; in-window requests, configuration requests and secondary requests ignore peer_claim_i.
- R13: A write with reg_we_i high loads, by reg_sel_i: 0 I/O base and 1 I/O limit from data bits [31:12]; 2 memory base and 3 memory limit from bits [31:20]; 4 prefetchable base and 5 prefetchable limit from bits [63:20]; 6 bus numbers primary [7:0], secondary [15:8], subordinate [23:16]; 7 subtractive enable from bit 0. It applies to requests presented from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 3 | Register select for the write |
| reg_wdata_i | input | 64 | Write data |
| req_valid_i | input | 1 | Request present this cycle |
| req_side_i | input | 1 | Arrival side: 0 primary, 1 secondary |
| req_kind_i | input | 2 | 0 I/O, 1 memory, 2 configuration |
| req_addr_i | input | 64 | Request address (I/O and memory) |
| req_bus_i | input | 8 | Target bus number (configuration) |
| peer_claim_i | input | 1 | Another agent claimed the request issued one cycle earlier |
| fwd_valid_o | output | 1 | Result valid |
| fwd_route_o | output | 2 | 0 none, 1 down, 2 up |
| fwd_type0_o | output | 1 | Downstream configuration access converts to type 0 |

## Verification
On every cycle the assertions tie each result back to the request held in the middle stage: an upward route only ever follows a secondary memory request that missed both windows, a secondary in-window request is never routed, a subtractive candidate seen with a peer claim stays unclaimed, the type-0 flag only accompanies a downward route, and a write to the control register lands in the next cycle. What they cannot show is that the window comparisons use the right bits, inclusive page edges and the 4 GB cut, and that a disabled window behaves as empty; the bench shows those through chosen addresses on both sides of each edge, equal-limit windows, bus numbers around the secondary and subordinate values, and subtractive requests with and without a peer claim.

// File: rtl/p2p_pkg.sv
package p2p_pkg;

  typedef enum logic [1:0] {
    KIND_IO  = 2'd0,
    KIND_MEM = 2'd1,
    KIND_CFG = 2'd2
  } req_kind_e;

  typedef enum logic [1:0] {
    ROUTE_NONE = 2'd0,
    ROUTE_DOWN = 2'd1,
    ROUTE_UP   = 2'd2
  } route_e;

  typedef enum logic [2:0] {
    SEL_IO_BASE  = 3'd0,
    SEL_IO_LIM   = 3'd1,
    SEL_MEM_BASE = 3'd2,
    SEL_MEM_LIM  = 3'd3,
    SEL_PF_BASE  = 3'd4,
    SEL_PF_LIM   = 3'd5,
    SEL_BUS      = 3'd6,
    SEL_CTRL     = 3'd7
  } reg_sel_e;

  localparam logic SIDE_PRI = 1'b0;
  localparam logic SIDE_SEC = 1'b1;

endpackage

// File: rtl/p2p_window_cmp.sv
module p2p_window_cmp #(
  parameter int ADDR_W = 64,
  parameter int LO     = 20,
  parameter int PG_W   = 12
) (
  input  logic [PG_W-1:0]   base_pg_i,
  input  logic [PG_W-1:0]   limit_pg_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              en_o,
  output logic              hit_o
);
  localparam int TOP = LO + PG_W;

  logic [PG_W-1:0] addr_pg;
  logic            upper_ok;
  logic            unused_lo;

  assign addr_pg   = addr_i[TOP-1:LO];
  assign unused_lo = ^addr_i[LO-1:0];

  generate
    if (TOP < ADDR_W) begin : g_upper
      assign upper_ok = (addr_i[ADDR_W-1:TOP] == '0);
    end else begin : g_full
      assign upper_ok = 1'b1;
    end
  endgenerate

  // window is live only with a strictly larger limit
  assign en_o  = limit_pg_i > base_pg_i;
  assign hit_o = en_o && upper_ok && (addr_pg >= base_pg_i) && (addr_pg <= limit_pg_i);

endmodule

// File: rtl/p2p_bus_route.sv
module p2p_bus_route #(
  parameter int BUS_W = 8
) (
  input  logic [BUS_W-1:0] pri_bus_i,
  input  logic [BUS_W-1:0] sec_bus_i,
  input  logic [BUS_W-1:0] sub_bus_i,
  input  logic [BUS_W-1:0] bus_i,
  output logic             type0_o,
  output logic             type1_o
);
  logic not_pri;

  assign not_pri = bus_i != pri_bus_i;
  assign type0_o = not_pri && (bus_i == sec_bus_i);
  assign type1_o = not_pri && (bus_i > sec_bus_i) && (bus_i <= sub_bus_i);

endmodule

// File: rtl/p2p_cfg_regs.sv
module p2p_cfg_regs import p2p_pkg::*; #(
  parameter int ADDR_W  = 64,
  parameter int BUS_W   = 8,
  parameter int IO_LO   = 12,
  parameter int IO_TOP  = 32,
  parameter int MEM_LO  = 20,
  parameter int MEM_TOP = 32,
  parameter int PF_LO   = 20,
  localparam int IO_PG_W  = IO_TOP - IO_LO,
  localparam int MEM_PG_W = MEM_TOP - MEM_LO,
  localparam int PF_PG_W  = ADDR_W - PF_LO
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [2:0]          sel_i,
  input  logic [ADDR_W-1:0]   wdata_i,
  output logic [IO_PG_W-1:0]  io_base_o,
  output logic [IO_PG_W-1:0]  io_lim_o,
  output logic [MEM_PG_W-1:0] mem_base_o,
  output logic [MEM_PG_W-1:0] mem_lim_o,
  output logic [PF_PG_W-1:0]  pf_base_o,
  output logic [PF_PG_W-1:0]  pf_lim_o,
  output logic [BUS_W-1:0]    pri_bus_o,
  output logic [BUS_W-1:0]    sec_bus_o,
  output logic [BUS_W-1:0]    sub_bus_o,
  output logic                sub_en_o
);
  reg_sel_e sel;
  assign sel = reg_sel_e'(sel_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      io_base_o  <= '0;
      io_lim_o   <= '0;
      mem_base_o <= '0;
      mem_lim_o  <= '0;
      pf_base_o  <= '0;
      pf_lim_o   <= '0;
      pri_bus_o  <= '0;
      sec_bus_o  <= '0;
      sub_bus_o  <= '0;
      sub_en_o   <= 1'b0;
    end else if (we_i) begin
      unique case (sel)
        SEL_IO_BASE:  io_base_o  <= wdata_i[IO_TOP-1:IO_LO];
        SEL_IO_LIM:   io_lim_o   <= wdata_i[IO_TOP-1:IO_LO];
        SEL_MEM_BASE: mem_base_o <= wdata_i[MEM_TOP-1:MEM_LO];
        SEL_MEM_LIM:  mem_lim_o  <= wdata_i[MEM_TOP-1:MEM_LO];
        SEL_PF_BASE:  pf_base_o  <= wdata_i[ADDR_W-1:PF_LO];
        SEL_PF_LIM:   pf_lim_o   <= wdata_i[ADDR_W-1:PF_LO];
        SEL_BUS: begin
          pri_bus_o <= wdata_i[BUS_W-1:0];
          sec_bus_o <= wdata_i[2*BUS_W-1:BUS_W];
          sub_bus_o <= wdata_i[3*BUS_W-1:2*BUS_W];
        end
        SEL_CTRL:     sub_en_o   <= wdata_i[0];
        default: ;
      endcase
    end
  end

  p_ctrl_wr_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'd7) |=> (sub_en_o == $past(wdata_i[0])));

  p_bus_wr_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && sel_i == 3'd6) |=> (sec_bus_o == $past(wdata_i[2*BUS_W-1:BUS_W])));

endmodule

// File: rtl/p2p_fwd_decoder.sv
module p2p_fwd_decoder import p2p_pkg::*; #(
  parameter int ADDR_W  = 64,
  parameter int BUS_W   = 8,
  parameter int IO_LO   = 12,
  parameter int IO_TOP  = 32,
  parameter int MEM_LO  = 20,
  parameter int MEM_TOP = 32,
  parameter int PF_LO   = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [2:0]        reg_sel_i,
  input  logic [ADDR_W-1:0] reg_wdata_i,
  input  logic              req_valid_i,
  input  logic              req_side_i,
  input  logic [1:0]        req_kind_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [BUS_W-1:0]  req_bus_i,
  input  logic              peer_claim_i,
  output logic              fwd_valid_o,
  output logic [1:0]        fwd_route_o,
  output logic              fwd_type0_o
);
  localparam int IO_PG_W  = IO_TOP - IO_LO;
  localparam int MEM_PG_W = MEM_TOP - MEM_LO;
  localparam int PF_PG_W  = ADDR_W - PF_LO;

  logic [IO_PG_W-1:0]  io_base, io_lim;
  logic [MEM_PG_W-1:0] mem_base, mem_lim;
  logic [PF_PG_W-1:0]  pf_base, pf_lim;
  logic [BUS_W-1:0]    pri_bus, sec_bus, sub_bus;
  logic                sub_en;

  p2p_cfg_regs #(
    .ADDR_W(ADDR_W), .BUS_W(BUS_W), .IO_LO(IO_LO), .IO_TOP(IO_TOP),
    .MEM_LO(MEM_LO), .MEM_TOP(MEM_TOP), .PF_LO(PF_LO)
  ) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .sel_i(reg_sel_i), .wdata_i(reg_wdata_i),
    .io_base_o(io_base), .io_lim_o(io_lim),
    .mem_base_o(mem_base), .mem_lim_o(mem_lim),
    .pf_base_o(pf_base), .pf_lim_o(pf_lim),
    .pri_bus_o(pri_bus), .sec_bus_o(sec_bus), .sub_bus_o(sub_bus),
    .sub_en_o(sub_en)
  );

  logic io_en, io_hit, mem_en, mem_hit, pf_en, pf_hit;
  logic unused_en;
  assign unused_en = io_en ^ mem_en ^ pf_en;

  p2p_window_cmp #(.ADDR_W(ADDR_W), .LO(IO_LO), .PG_W(IO_PG_W)) u_io_win (
    .base_pg_i(io_base), .limit_pg_i(io_lim), .addr_i(req_addr_i),
    .en_o(io_en), .hit_o(io_hit));

  p2p_window_cmp #(.ADDR_W(ADDR_W), .LO(MEM_LO), .PG_W(MEM_PG_W)) u_mem_win (
    .base_pg_i(mem_base), .limit_pg_i(mem_lim), .addr_i(req_addr_i),
    .en_o(mem_en), .hit_o(mem_hit));

  p2p_window_cmp #(.ADDR_W(ADDR_W), .LO(PF_LO), .PG_W(PF_PG_W)) u_pf_win (
    .base_pg_i(pf_base), .limit_pg_i(pf_lim), .addr_i(req_addr_i),
    .en_o(pf_en), .hit_o(pf_hit));

  logic bus_t0, bus_t1;

  p2p_bus_route #(.BUS_W(BUS_W)) u_bus (
    .pri_bus_i(pri_bus), .sec_bus_i(sec_bus), .sub_bus_i(sub_bus),
    .bus_i(req_bus_i), .type0_o(bus_t0), .type1_o(bus_t1));

  // positive decode, stage 0
  req_kind_e kind;
  route_e    pos_route;
  logic      in_mem, in_win, sub_cand, t0_d;

  assign kind   = req_kind_e'(req_kind_i);
  assign in_mem = mem_hit || pf_hit;

  always_comb begin
    in_win    = 1'b0;
    pos_route = ROUTE_NONE;
    sub_cand  = 1'b0;
    t0_d      = 1'b0;
    unique case (kind)
      KIND_IO:  in_win = io_hit;
      KIND_MEM: in_win = in_mem;
      default:  in_win = 1'b0;
    endcase
    if (req_side_i == SIDE_PRI) begin
      unique case (kind)
        KIND_IO, KIND_MEM: begin
          pos_route = in_win ? ROUTE_DOWN : ROUTE_NONE;
          sub_cand  = sub_en && !in_win;
        end
        KIND_CFG: begin
          pos_route = (bus_t0 || bus_t1) ? ROUTE_DOWN : ROUTE_NONE;
          t0_d      = bus_t0;
        end
        default: ;
      endcase
    end else if (kind == KIND_MEM) begin
      // DMA goes up unless it targets a peer below the bridge
      pos_route = in_mem ? ROUTE_NONE : ROUTE_UP;
    end
  end

  // stage 1: wait for the peer claim slot
  logic      s1_valid, s1_sub_cand, s1_t0, s1_side, s1_in_win, s1_sub_en;
  route_e    s1_route;
  req_kind_e s1_kind;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_valid    <= 1'b0;
      s1_route    <= ROUTE_NONE;
      s1_sub_cand <= 1'b0;
      s1_t0       <= 1'b0;
      s1_side     <= SIDE_PRI;
      s1_kind     <= KIND_IO;
      s1_in_win   <= 1'b0;
      s1_sub_en   <= 1'b0;
    end else begin
      s1_valid <= req_valid_i;
      if (req_valid_i) begin
        s1_route    <= pos_route;
        s1_sub_cand <= sub_cand;
        s1_t0       <= t0_d;
        s1_side     <= req_side_i;
        s1_kind     <= kind;
        s1_in_win   <= in_win;
        s1_sub_en   <= sub_en;
      end
    end
  end

  // stage 2: final claim
  route_e fin_route;
  assign fin_route = s1_sub_cand ? (peer_claim_i ? ROUTE_NONE : ROUTE_DOWN) : s1_route;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fwd_valid_o <= 1'b0;
      fwd_route_o <= ROUTE_NONE;
      fwd_type0_o <= 1'b0;
    end else begin
      fwd_valid_o <= s1_valid;
      if (s1_valid) begin
        fwd_route_o <= fin_route;
        fwd_type0_o <= s1_t0;
      end else begin
        fwd_route_o <= ROUTE_NONE;
        fwd_type0_o <= 1'b0;
      end
    end
  end

  p_res_follows_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_valid_o |-> $past(s1_valid));

  p_up_only_dma_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_valid_o && fwd_route_o == ROUTE_UP) |->
      $past(s1_side == SIDE_SEC && s1_kind == KIND_MEM && !s1_in_win));

  p_peer_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(s1_valid && s1_side == SIDE_SEC && s1_in_win) |-> (fwd_route_o == ROUTE_NONE));

  p_miss_dropped_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(s1_valid && !s1_sub_en && s1_side == SIDE_PRI && s1_kind != KIND_CFG && !s1_in_win)
      |-> (fwd_route_o == ROUTE_NONE));

  p_type0_down_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_type0_o |-> (fwd_valid_o && fwd_route_o == ROUTE_DOWN));

  p_sub_yield_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(s1_valid && s1_sub_cand && peer_claim_i) |-> (fwd_route_o == ROUTE_NONE));

endmodule

// File: tb/p2p_fwd_decoder_tb_top.sv
module p2p_fwd_decoder_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] RT_NONE = 2'd0, RT_DOWN = 2'd1, RT_UP = 2'd2;
  localparam logic [1:0] K_IO = 2'd0, K_MEM = 2'd1, K_CFG = 2'd2;
  localparam logic PRI = 1'b0, SEC = 1'b1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [2:0]  reg_sel_i = '0;
  logic [63:0] reg_wdata_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_side_i = 1'b0;
  logic [1:0]  req_kind_i = '0;
  logic [63:0] req_addr_i = '0;
  logic [7:0]  req_bus_i = '0;
  logic        peer_claim_i = 1'b0;
  logic        fwd_valid_o;
  logic [1:0]  fwd_route_o;
  logic        fwd_type0_o;

  p2p_fwd_decoder dut_i (
    .clk_i, .rst_ni, .reg_we_i, .reg_sel_i, .reg_wdata_i,
    .req_valid_i, .req_side_i, .req_kind_i, .req_addr_i, .req_bus_i,
    .peer_claim_i, .fwd_valid_o, .fwd_route_o, .fwd_type0_o);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  typedef struct {
    logic [1:0] route;
    logic       t0;
    int         cyc;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int   checks = 0;
  int   failures = 0;
  int   cyc = 0;
  logic pend_peer = 1'b0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    reg_we_i     = 1'b0;
    req_valid_i  = 1'b0;
    peer_claim_i = pend_peer;
    pend_peer    = 1'b0;
  endtask

  task automatic wr(input logic [2:0] sel, input logic [63:0] data);
    @(negedge clk_i);
    req_valid_i  = 1'b0;
    peer_claim_i = pend_peer;
    pend_peer    = 1'b0;
    reg_we_i     = 1'b1;
    reg_sel_i    = sel;
    reg_wdata_i  = data;
  endtask

  task automatic issue(input logic side, input logic [1:0] kind, input logic [63:0] addr,
                       input logic [7:0] bus, input logic peer,
                       input logic [1:0] er, input logic et0, input string tag);
    exp_t e;
    @(negedge clk_i);
    reg_we_i     = 1'b0;
    peer_claim_i = pend_peer;
    pend_peer    = peer;
    req_valid_i  = 1'b1;
    req_side_i   = side;
    req_kind_i   = kind;
    req_addr_i   = addr;
    req_bus_i    = bus;
    e.route = er;
    e.t0    = et0;
    e.cyc   = cyc + 2;
    e.tag   = tag;
    exp_q.push_back(e);
  endtask

  // monitor
  always @(negedge clk_i) begin
    if (rst_ni && fwd_valid_o) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R2 unexpected result", 1, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        chk(fwd_route_o == e.route, e.tag, fwd_route_o, e.route);
        chk(fwd_type0_o == e.t0, {e.tag, " type0"}, fwd_type0_o, e.t0);
        chk(cyc == e.cyc, "R2 latency", cyc, e.cyc);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    failures++;
    checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(fwd_valid_o == 1'b0, "R1 valid in reset", fwd_valid_o, 0);
    chk(fwd_route_o == RT_NONE, "R1 route in reset", fwd_route_o, RT_NONE);
    rst_ni = 1'b1;
    idle();
    // R1: windows disabled out of reset
    issue(PRI, K_MEM, 64'h0, 8'd0, 1'b0, RT_NONE, 1'b0, "R1 mem after reset");
    issue(PRI, K_IO,  64'h0, 8'd0, 1'b0, RT_NONE, 1'b0, "R1 io after reset");
    // R13: program windows and bus numbers
    wr(3'd0, 64'h0000_2000);
    wr(3'd1, 64'h0000_4000);
    wr(3'd2, 64'hC000_0000);
    wr(3'd3, 64'hC0F0_0000);
    wr(3'd4, 64'h1_0000_0000);
    wr(3'd5, 64'h1_0FF0_0000);
    wr(3'd6, 64'h05_02_01);
    // R3
    issue(PRI, K_IO, 64'h0000_4FFF, 8'd0, 1'b0, RT_DOWN, 1'b0, "R3 io top page");
    issue(PRI, K_IO, 64'h0000_2000, 8'd0, 1'b0, RT_DOWN, 1'b0, "R3 io base");
    issue(PRI, K_IO, 64'h0000_5000, 8'd0, 1'b0, RT_NONE, 1'b0, "R3 io above");
    issue(PRI, K_IO, 64'h0000_1FFF, 8'd0, 1'b0, RT_NONE, 1'b0, "R3 io below");
    issue(PRI, K_IO, 64'h1_0000_3000, 8'd0, 1'b0, RT_NONE, 1'b0, "R3 io upper bits");
    // R4
    issue(PRI, K_MEM, 64'hC0FF_FFFC, 8'd0, 1'b0, RT_DOWN, 1'b0, "R4 mem top");
    issue(PRI, K_MEM, 64'hC100_0000, 8'd0, 1'b0, RT_NONE, 1'b0, "R4 mem above");
    issue(PRI, K_MEM, 64'h1_C000_0000, 8'd0, 1'b0, RT_NONE, 1'b0, "R4 mem alias above 4G");
    // R5
    issue(PRI, K_MEM, 64'h1_0800_0000, 8'd0, 1'b0, RT_DOWN, 1'b0, "R5 pf hit");
    issue(PRI, K_MEM, 64'h2_0000_0000, 8'd0, 1'b0, RT_NONE, 1'b0, "R5 pf miss");
    // R9
    issue(PRI, K_MEM, 64'h9000_0000, 8'd0, 1'b1, RT_NONE, 1'b0, "R9 miss no subtractive");
    // R7 / R8
    issue(SEC, K_MEM, 64'h8000_0000, 8'd0, 1'b0, RT_UP,   1'b0, "R7 dma up");
    issue(SEC, K_MEM, 64'h3_0000_0000, 8'd0, 1'b0, RT_UP, 1'b0, "R7 dma high up");
    issue(SEC, K_MEM, 64'hC010_0000, 8'd0, 1'b0, RT_NONE, 1'b0, "R8 peer mem");
    issue(SEC, K_MEM, 64'h1_0800_0000, 8'd0, 1'b0, RT_NONE, 1'b0, "R8 peer pf");
    issue(SEC, K_IO,  64'h0000_8000, 8'd0, 1'b0, RT_NONE, 1'b0, "R8 sec io");
    issue(SEC, K_CFG, 64'h0, 8'd2, 1'b0, RT_NONE, 1'b0, "R8 sec cfg");
    // R10 / R11
    issue(PRI, K_CFG, 64'h0, 8'd2, 1'b0, RT_DOWN, 1'b1, "R10 cfg type0");
    issue(PRI, K_CFG, 64'h0, 8'd3, 1'b0, RT_DOWN, 1'b0, "R11 cfg type1 low");
    issue(PRI, K_CFG, 64'h0, 8'd5, 1'b0, RT_DOWN, 1'b0, "R11 cfg type1 sub");
    issue(PRI, K_CFG, 64'h0, 8'd6, 1'b0, RT_NONE, 1'b0, "R11 cfg above sub");
    issue(PRI, K_CFG, 64'h0, 8'd1, 1'b0, RT_NONE, 1'b0, "R11 cfg primary bus");
    issue(PRI, K_CFG, 64'h0, 8'd0, 1'b0, RT_NONE, 1'b0, "R11 cfg below");
    // R6: equal or lower limit disables
    wr(3'd1, 64'h0000_2000);
    issue(PRI, K_IO, 64'h0000_2000, 8'd0, 1'b0, RT_NONE, 1'b0, "R6 io equal limit");
    wr(3'd3, 64'hB000_0000);
    issue(SEC, K_MEM, 64'hC010_0000, 8'd0, 1'b0, RT_UP, 1'b0, "R6 mem disabled dma up");
    issue(PRI, K_MEM, 64'hC010_0000, 8'd0, 1'b0, RT_NONE, 1'b0, "R6 mem disabled pri");
    // R12 / R13 subtractive
    wr(3'd7, 64'h1);
    issue(PRI, K_MEM, 64'h9000_0000, 8'd0, 1'b0, RT_DOWN, 1'b0, "R12 sub no peer");
    issue(PRI, K_MEM, 64'h9000_0000, 8'd0, 1'b1, RT_NONE, 1'b0, "R12 sub peer claimed");
    issue(PRI, K_IO,  64'h0000_7000, 8'd0, 1'b0, RT_DOWN, 1'b0, "R12 sub io");
    issue(PRI, K_MEM, 64'h1_0800_0000, 8'd0, 1'b1, RT_DOWN, 1'b0, "R12 in window ignores peer");
    issue(PRI, K_CFG, 64'h0, 8'd7, 1'b0, RT_NONE, 1'b0, "R12 cfg not subtractive");
    issue(SEC, K_MEM, 64'h9000_0000, 8'd0, 1'b1, RT_UP, 1'b0, "R12 sec ignores peer");
    wr(3'd7, 64'h0);
    issue(PRI, K_MEM, 64'h9000_0000, 8'd0, 1'b0, RT_NONE, 1'b0, "R13 sub disabled");
    repeat (5) idle();
    chk(exp_q.size() == 0, "R2 results outstanding", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule